// File: doc/BRIEF.md
# Receive Data-Link Message FIFO Controller

This block buffers the bytes a serial data-link receiver extracts from the line. It holds them in a 64-location queue for a processor to read. Incoming bytes are grouped into unformatted messages. A message ends when its byte count reaches a fill limit, or when the queue crosses a near-full level that software programs as a number of free locations. At each message end the block raises an interrupt and places an 8-bit status word in the queue directly behind the last data byte. The processor can then find message boundaries while it drains the data.

The fill limit is chosen by a 2-bit code, and its meaning depends on the line mode. In T1 mode the limits are multiples of six bytes, and in E1 mode they are multiples of eight. Bytes arrive either 8 bits wide or packed as 6 bits. Every interrupt is a sticky high level with its own clear strobe. A separate near-full level flag stays up until the processor has read enough entries after the event.

Top module: `rdlMsgFifo`

## Requirements
- R1: The queue holds 64 entries. A write while 64 entries are stored is dropped and sets the sticky `overflow` output. The occupancy never exceeds 64.
- R2: When `rdEn` is high and the queue is not empty, the oldest entry appears on `rdData` after the clock edge and is removed. When `rdEn` is high and the queue is empty, `rdData` becomes 0 and the queue is left unchanged.
- R3: With `pack6` = 1 only bits 5:0 of `wrByte` are stored and bits 7:6 read back as 0. With `pack6` = 0 all 8 bits are stored.
- R4: The fill limit is decoded from `fillCode` and `isE1`. With `isE1` = 0, codes 01, 10 and 11 give 6, 12 and 18 bytes. With `isE1` = 1, the same codes give 8, 16 and 24 bytes. Code 00 disables the limit in both modes.
- R5: When the accepted write brings the current message count to the fill limit, `fullIrq` sets and the status word 8'h83 is stored right after that data byte. Bit 7 marks status, bit 1 marks a fill-limit end and bit 0 marks a partial message. The message count then restarts at zero.
- R6: A near-full event occurs when an accepted write moves the number of free locations from above `nearThresh` to at most `nearThresh`. The free count includes any fill status word written in the same cycle. The event sets `nearIrq` and `nearLevel`.
- R7: A near-full event that is not also a fill-limit end sets `msgIrq` and stores the status word 8'h81 right after the data byte. This word has bit 7 and bit 0 set and bit 1 clear. The message count restarts at zero.
- R8: `nearLevel` stays high until the processor has completed 64 minus `nearThresh` successful reads after the event, and clears on the last of them.
- R9: Any change of `fillCode` or `isE1` restarts the message count at zero.
- R10: `fullIrq`, `nearIrq`, `msgIrq` and `overflow` stay high until their clear input is pulsed. A set condition in the same cycle as the clear pulse wins.
- R11: A status word that finds no free location is dropped and sets `overflow`. The interrupt and the count restart still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte-write strobe from the bit extractor |
| wrByte | input | 8 | Received byte |
| pack6 | input | 1 | 1: 6-bit packed bytes, 0: 8-bit bytes |
| isE1 | input | 1 | Line mode, 1: E1, 0: T1 |
| fillCode | input | 2 | Fill-limit select code |
| nearThresh | input | 6 | Near-full threshold in free locations |
| rdEn | input | 1 | Processor read strobe |
| rdData | output | 8 | Registered read data |
| fifoEmpty | output | 1 | Queue holds no entry |
| fullIrq | output | 1 | Sticky fill-limit interrupt |
| clrFull | input | 1 | Clear pulse for fullIrq |
| nearIrq | output | 1 | Sticky near-full interrupt |
| clrNear | input | 1 | Clear pulse for nearIrq |
| nearLevel | output | 1 | Near-full level flag |
| msgIrq | output | 1 | Sticky message interrupt for a near-full partial message |
| clrMsg | input | 1 | Clear pulse for msgIrq |
| overflow | output | 1 | Sticky lost-write flag |
| clrOvf | input | 1 | Clear pulse for overflow |

## Verification
The hardest case to reach is a near-full crossing with no room left for its status word. That happens only when the threshold is zero and the write that fills the 64th location ends a message. The bench reaches it by disabling the fill limit, setting the threshold to zero and writing exactly 64 bytes. It then clears `overflow`, so that the following dropped write can be told apart from the dropped status word. A second hard case is the restart of the message count on a configuration change. The bench toggles the fill code away and back in the middle of a message, then checks that the full interrupt waits for a complete new message.

// File: rtl/rdl_msg_pkg.sv
package rdl_msg_pkg;

  localparam int BYTE_W = 8;

  // status words: bit7 = status entry, bit1 = fill-limit end, bit0 = partial
  localparam logic [BYTE_W-1:0] STAT_FILL = 8'h83;
  localparam logic [BYTE_W-1:0] STAT_NEAR = 8'h81;

  // strobes from control to datapath
  typedef struct packed {
    logic              putData;
    logic              putStat;
    logic [BYTE_W-1:0] dataByte;
    logic [BYTE_W-1:0] statByte;
    logic              rdReq;
    logic              rdPop;
  } fifoCmd_t;

endpackage

// File: rtl/rdlFifoDatapath.sv
module rdlFifoDatapath
  import rdl_msg_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rdData
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] statAddr;
  logic [ADDR_W-1:0] wrStep;
  logic [CNT_W-1:0]  addCnt;

  // the status word lands behind the data byte written in the same cycle
  assign statAddr = cmd.putData ? wrPtr + ADDR_W'(1) : wrPtr;
  assign wrStep   = ADDR_W'(cmd.putData) + ADDR_W'(cmd.putStat);
  assign addCnt   = CNT_W'(cmd.putData) + CNT_W'(cmd.putStat);

  always_ff @(posedge clk) begin
    if (cmd.putData) mem[wrPtr] <= cmd.dataByte;
    if (cmd.putStat) mem[statAddr] <= cmd.statByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      wrPtr <= wrPtr + wrStep;
      if (cmd.rdPop) rdPtr <= rdPtr + ADDR_W'(1);
      count <= count + addCnt - CNT_W'(cmd.rdPop);
      if (cmd.rdReq) rdData <= cmd.rdPop ? mem[rdPtr] : '0;
    end
  end

endmodule

// File: rtl/rdlMsgControl.sv
module rdlMsgControl
  import rdl_msg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int T1_BASE = 6,
  parameter int E1_BASE = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1,
  localparam int MAX_LIM = 3 * ((T1_BASE > E1_BASE) ? T1_BASE : E1_BASE),
  localparam int MSG_W = $clog2(MAX_LIM + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              pack6,
  input  logic              isE1,
  input  logic [1:0]        fillCode,
  input  logic [ADDR_W-1:0] nearThresh,
  input  logic              rdEn,
  input  logic              clrFull,
  input  logic              clrNear,
  input  logic              clrMsg,
  input  logic              clrOvf,
  input  logic [CNT_W-1:0]  count,
  output fifoCmd_t          cmd,
  output logic              fullIrq,
  output logic              nearIrq,
  output logic              msgIrq,
  output logic              nearLevel,
  output logic              overflow
);

  logic [MSG_W-1:0] msgCnt;
  logic [MSG_W-1:0] baseCnt;
  logic [MSG_W-1:0] nextMsg;
  logic [MSG_W-1:0] fillLimit;
  logic [1:0]       prevCode;
  logic             prevE1;
  logic             cfgChanged;
  logic [CNT_W-1:0] freeNow;
  logic [CNT_W-1:0] afterCnt;
  logic [CNT_W-1:0] freeAfter;
  logic [CNT_W-1:0] threshExt;
  logic [CNT_W-1:0] drainCnt;
  logic             room;
  logic             acceptData;
  logic             spaceForStat;
  logic             fillHit;
  logic             nearHit;
  logic             nearStat;
  logic             needStat;
  logic             statDrop;
  logic             rdPop;

  // fill-limit decode: code times the base of the line mode, code 0 off
  always_comb begin
    logic [MSG_W-1:0] base;
    base = isE1 ? MSG_W'(E1_BASE) : MSG_W'(T1_BASE);
    unique case (fillCode)
      2'd0:    fillLimit = '0;
      2'd1:    fillLimit = base;
      2'd2:    fillLimit = MSG_W'(2 * base);
      default: fillLimit = MSG_W'(3 * base);
    endcase
  end

  assign cfgChanged   = (fillCode != prevCode) || (isE1 != prevE1);
  assign room         = count < CNT_W'(DEPTH);
  assign acceptData   = wrEn && room;
  assign freeNow      = CNT_W'(DEPTH) - count;
  assign spaceForStat = freeNow > CNT_W'(1);
  assign threshExt    = CNT_W'(nearThresh);

  assign baseCnt  = cfgChanged ? '0 : msgCnt;
  assign nextMsg  = baseCnt + MSG_W'(1);
  assign fillHit  = acceptData && (fillLimit != '0) && (nextMsg == fillLimit);

  assign afterCnt  = count + CNT_W'(1) + CNT_W'(fillHit && spaceForStat);
  assign freeAfter = CNT_W'(DEPTH) - afterCnt;
  assign nearHit   = acceptData && (freeNow > threshExt) && (freeAfter <= threshExt);
  assign nearStat  = nearHit && !fillHit;
  assign needStat  = fillHit || nearStat;
  assign statDrop  = needStat && !spaceForStat;
  assign rdPop     = rdEn && (count != '0);

  always_comb begin
    cmd          = '0;
    cmd.putData  = acceptData;
    cmd.dataByte = pack6 ? {2'b00, wrByte[5:0]} : wrByte;
    cmd.putStat  = needStat && spaceForStat;
    cmd.statByte = fillHit ? STAT_FILL : STAT_NEAR;
    cmd.rdReq    = rdEn;
    cmd.rdPop    = rdPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgCnt   <= '0;
      prevCode <= '0;
      prevE1   <= 1'b0;
    end else begin
      prevCode <= fillCode;
      prevE1   <= isE1;
      if (acceptData) msgCnt <= (fillHit || nearHit) ? '0 : nextMsg;
      else            msgCnt <= baseCnt;
    end
  end

  // sticky flags: a set condition beats a clear pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullIrq  <= 1'b0;
      nearIrq  <= 1'b0;
      msgIrq   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (fillHit)      fullIrq <= 1'b1;
      else if (clrFull) fullIrq <= 1'b0;
      if (nearHit)      nearIrq <= 1'b1;
      else if (clrNear) nearIrq <= 1'b0;
      if (nearStat)     msgIrq <= 1'b1;
      else if (clrMsg)  msgIrq <= 1'b0;
      if ((wrEn && !room) || statDrop) overflow <= 1'b1;
      else if (clrOvf)                 overflow <= 1'b0;
    end
  end

  // level flag drains after DEPTH - threshold successful reads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nearLevel <= 1'b0;
      drainCnt  <= '0;
    end else if (nearHit) begin
      nearLevel <= 1'b1;
      drainCnt  <= CNT_W'(DEPTH) - threshExt;
    end else if (nearLevel && rdPop) begin
      drainCnt <= drainCnt - CNT_W'(1);
      if (drainCnt == CNT_W'(1)) nearLevel <= 1'b0;
    end
  end

endmodule

// File: rtl/rdlMsgFifo.sv
module rdlMsgFifo
  import rdl_msg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int T1_BASE = 6,
  parameter int E1_BASE = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrByte,
  input  logic              pack6,
  input  logic              isE1,
  input  logic [1:0]        fillCode,
  input  logic [ADDR_W-1:0] nearThresh,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              fifoEmpty,
  output logic              fullIrq,
  input  logic              clrFull,
  output logic              nearIrq,
  input  logic              clrNear,
  output logic              nearLevel,
  output logic              msgIrq,
  input  logic              clrMsg,
  output logic              overflow,
  input  logic              clrOvf
);

  fifoCmd_t         fifoCmd;
  logic [CNT_W-1:0] fifoCount;

  rdlMsgControl #(
    .DEPTH(DEPTH), .T1_BASE(T1_BASE), .E1_BASE(E1_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .pack6(pack6),
    .isE1(isE1), .fillCode(fillCode), .nearThresh(nearThresh), .rdEn(rdEn),
    .clrFull(clrFull), .clrNear(clrNear), .clrMsg(clrMsg), .clrOvf(clrOvf),
    .count(fifoCount), .cmd(fifoCmd), .fullIrq(fullIrq), .nearIrq(nearIrq),
    .msgIrq(msgIrq), .nearLevel(nearLevel), .overflow(overflow)
  );

  rdlFifoDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .count(fifoCount), .rdData(rdData)
  );

  assign fifoEmpty = (fifoCount == '0);

endmodule

// File: rtl/rdlMsgFifo_chk.sv
module rdlMsgFifo_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [7:0]       rdData,
  input logic [CNT_W-1:0] count,
  input logic             fullIrq,
  input logic             nearIrq,
  input logic             msgIrq,
  input logic             nearLevel,
  input logic             overflow,
  input logic             clrOvf
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R1
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && count == '0) |=> (rdData == 8'h00)); // R2
  AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullIrq) |-> $past(wrEn)); // R5
  AST_LEVEL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nearLevel) |-> nearIrq); // R6
  AST_MSG_WITH_NEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgIrq) |-> nearIrq); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clrOvf) |=> overflow); // R10

endmodule

bind rdlMsgFifo rdlMsgFifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .count(fifoCount), .fullIrq(fullIrq), .nearIrq(nearIrq), .msgIrq(msgIrq),
  .nearLevel(nearLevel), .overflow(overflow), .clrOvf(clrOvf)
);

// File: tb/test_rdlMsgFifo.sv
module test_rdlMsgFifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrByte = '0;
  logic       pack6 = 1'b0;
  logic       isE1 = 1'b0;
  logic [1:0] fillCode = '0;
  logic [5:0] nearThresh = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       fifoEmpty, fullIrq, nearIrq, nearLevel, msgIrq, overflow;
  logic       clrFull = 1'b0, clrNear = 1'b0, clrMsg = 1'b0, clrOvf = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  rdlMsgFifo i_rdlMsgFifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .pack6(pack6),
    .isE1(isE1), .fillCode(fillCode), .nearThresh(nearThresh), .rdEn(rdEn),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .fullIrq(fullIrq), .clrFull(clrFull),
    .nearIrq(nearIrq), .clrNear(clrNear), .nearLevel(nearLevel), .msgIrq(msgIrq),
    .clrMsg(clrMsg), .overflow(overflow), .clrOvf(clrOvf)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrOne(input logic [7:0] d, input logic alsoClrFull);
    @(negedge clk);
    wrEn = 1'b1; wrByte = d; clrFull = alsoClrFull;
    @(negedge clk);
    wrEn = 1'b0; clrFull = 1'b0;
  endtask

  task automatic rdOne(output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic pulseClr(input int which);
    @(negedge clk);
    clrFull = (which == 0); clrNear = (which == 1);
    clrMsg = (which == 2); clrOvf = (which == 3);
    @(negedge clk);
    clrFull = 1'b0; clrNear = 1'b0; clrMsg = 1'b0; clrOvf = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'h7F);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    doReset();
    check(fifoEmpty === 1'b1, "R2 reset empty", int'(fifoEmpty), 1);
    check({fullIrq, nearIrq, msgIrq, nearLevel, overflow} === 5'b0, "R10 reset flags",
          int'({fullIrq, nearIrq, msgIrq, nearLevel, overflow}), 0);
    check(rdData === 8'h00, "R2 reset rdData", int'(rdData), 0);

    // R4 R5 R10: fill-limit sweep over both line modes and all enabling codes
    for (int e1 = 0; e1 < 2; e1++) begin
      for (int code = 1; code < 4; code++) begin
        int lim;
        int idx;
        lim = code * ((e1 != 0) ? 8 : 6);
        isE1 = e1[0]; fillCode = 2'(code); nearThresh = 6'd0;
        doReset();
        idx = 0;
        for (int m = 0; m < 2; m++) begin
          for (int b = 0; b < lim - 1; b++) begin
            wrOne(pat(idx), 1'b0);
            idx++;
          end
          check(fullIrq === 1'b0, "R4 no early full", int'(fullIrq), 0);
          // second message: clear pulse coincides with the hit, set wins (R10)
          wrOne(pat(idx), m == 1);
          idx++;
          check(fullIrq === 1'b1, "R5 full at limit", int'(fullIrq), 1);
          if (m == 0) begin
            pulseClr(0);
            check(fullIrq === 1'b0, "R10 clear full", int'(fullIrq), 0);
          end
        end
        idx = 0;
        for (int m = 0; m < 2; m++) begin
          for (int b = 0; b < lim; b++) begin
            rdOne(rv);
            check(rv === pat(idx), "R5 data order", int'(rv), int'(pat(idx)));
            idx++;
          end
          rdOne(rv);
          check(rv === 8'h83, "R5 fill status word", int'(rv), 8'h83);
        end
        check(fifoEmpty === 1'b1, "R5 drained", int'(fifoEmpty), 1);
        check(nearIrq === 1'b0, "R6 no near event", int'(nearIrq), 0);
      end
    end

    // R4: code 00 disables the fill limit
    isE1 = 1'b0; fillCode = 2'd0; nearThresh = 6'd0;
    doReset();
    for (int i = 0; i < 30; i++) wrOne(pat(i), 1'b0);
    check(fullIrq === 1'b0, "R4 code 00 disabled", int'(fullIrq), 0);
    for (int i = 0; i < 30; i++) begin
      rdOne(rv);
      check(rv === pat(i), "R4 code 00 no status", int'(rv), int'(pat(i)));
    end

    // R9: changing the fill code restarts the message count
    isE1 = 1'b0; fillCode = 2'd1;
    doReset();
    for (int i = 0; i < 3; i++) wrOne(pat(i), 1'b0);
    @(negedge clk); fillCode = 2'd2;
    @(negedge clk); fillCode = 2'd1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) wrOne(pat(i), 1'b0);
    check(fullIrq === 1'b0, "R9 count restarted", int'(fullIrq), 0);
    wrOne(pat(5), 1'b0);
    check(fullIrq === 1'b1, "R9 full after new message", int'(fullIrq), 1);

    // R6 R7 R8: near-full at threshold 10, fill limit off
    fillCode = 2'd0; nearThresh = 6'd10;
    doReset();
    for (int i = 0; i < 53; i++) wrOne(pat(i), 1'b0);
    check(nearIrq === 1'b0, "R6 no early near", int'(nearIrq), 0);
    wrOne(pat(53), 1'b0);
    check(nearIrq === 1'b1, "R6 near irq", int'(nearIrq), 1);
    check(nearLevel === 1'b1, "R6 near level", int'(nearLevel), 1);
    check(msgIrq === 1'b1, "R7 msg irq", int'(msgIrq), 1);
    for (int i = 0; i < 53; i++) begin
      rdOne(rv);
      check(rv === pat(i), "R7 data before status", int'(rv), int'(pat(i)));
    end
    check(nearLevel === 1'b1, "R8 level held", int'(nearLevel), 1);
    rdOne(rv);
    check(rv === pat(53), "R7 last data", int'(rv), int'(pat(53)));
    check(nearLevel === 1'b0, "R8 level cleared", int'(nearLevel), 0);
    rdOne(rv);
    check(rv === 8'h81, "R7 near status word", int'(rv), 8'h81);
    pulseClr(2);
    check(msgIrq === 1'b0, "R10 clear msg", int'(msgIrq), 0);
    pulseClr(1);
    check(nearIrq === 1'b0, "R10 clear near", int'(nearIrq), 0);

    // R11 R1 R2 R3: threshold 0, fill off, 6-bit packing
    fillCode = 2'd0; nearThresh = 6'd0; pack6 = 1'b1;
    doReset();
    for (int i = 0; i < 63; i++) wrOne(8'(i | 8'hC0), 1'b0);
    check(overflow === 1'b0, "R1 no overflow below full", int'(overflow), 0);
    wrOne(8'hFF, 1'b0);
    check(overflow === 1'b1, "R11 status dropped", int'(overflow), 1);
    check(msgIrq === 1'b1, "R11 msg irq still set", int'(msgIrq), 1);
    pulseClr(3);
    check(overflow === 1'b0, "R10 clear overflow", int'(overflow), 0);
    wrOne(8'h11, 1'b0);
    check(overflow === 1'b1, "R1 write to full", int'(overflow), 1);
    for (int i = 0; i < 63; i++) begin
      rdOne(rv);
      check(rv === 8'(i & 8'h3F), "R3 6-bit packing", int'(rv), i & 8'h3F);
    end
    rdOne(rv);
    check(rv === 8'h3F, "R1 64th entry kept", int'(rv), 8'h3F);
    check(fifoEmpty === 1'b1, "R1 nothing extra stored", int'(fifoEmpty), 1);
    rdOne(rv);
    check(rv === 8'h00, "R2 empty read zero", int'(rv), 0);
    check(fifoEmpty === 1'b1, "R2 empty read no change", int'(fifoEmpty), 1);

    // R3: 8-bit packing keeps the upper bits
    pack6 = 1'b0;
    wrOne(8'hE7, 1'b0);
    rdOne(rv);
    check(rv === 8'hE7, "R3 8-bit packing", int'(rv), 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule